// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block generates the sequence of byte addresses that one DMA channel visits. Software supplies a start address, an inner count with a signed inner step, an outer count with a signed outer step, an element size and a few mode bits. The generator then holds the current element address on its output while the channel is active. On each accepted transfer it moves to the next element. Within a row the address moves by the inner step. When a row finishes, the outer step is applied instead, so the same engine can walk a plain rectangle, a strided block, or several interleaved streams. The outer step may be smaller than the inner step, or negative.

In one-dimensional mode the outer count is taken as one. The block marks the last element of each row and the last element of the transfer. After the final element it either stops, or in circular mode it reloads the captured start address and counts and keeps running. It can raise an interrupt pulse after every row or only after the whole transfer. The data path, the bus protocol and descriptor fetching are handled elsewhere.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After a synchronous reset, `active`, `irq` and `done` are 0.
- R2: A `start` pulse while idle and `en` is high makes `active` 1 from the next cycle. `addr` then equals `cfg_start`, and all configuration inputs are captured.
- R3: An accepted transfer (`xfer` while `active` and `en`) that is not the last in its row advances `addr` by the inner step times the element size. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 4 bytes. Steps are signed two's complement and sign-extended to 32 bits.
- R4: `row_end` is 1 exactly on the last element of each row. An accepted transfer there that is not the last of the transfer advances `addr` by the outer step times the element size. `last` is 1 exactly on the final element of the transfer.
- R5: With `cfg_two_d` = 0 the outer count is treated as 1, so the first row end is also `last`.
- R6: A count value of 0 means 65536 elements.
- R7: With `cfg_circular` = 0, the cycle after the final accepted transfer has `done` = 1 for one cycle and `active` = 0.
- R8: With `cfg_circular` = 1, the final accepted transfer gives a `done` pulse, keeps `active` at 1, and reloads `addr` and both counts from the captured configuration.
- R9: `irq` pulses for one cycle after an accepted row-end transfer when `cfg_irq_row` = 1. When `cfg_irq_row` = 0 it pulses only after the final transfer.
- R10: `start` and changes to the configuration inputs while `active` is 1 have no effect on the running sequence.
- R11: `en` low while active forces `active` to 0 on the next cycle, and no `irq` or `done` follows.
- R12: Without an accepted transfer, `addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low aborts |
| start | input | 1 | Start command pulse |
| cfg_start | input | 32 | Start byte address |
| cfg_x_count | input | 16 | Inner element count (0 = 65536) |
| cfg_x_step | input | 16 | Signed inner step in elements |
| cfg_y_count | input | 16 | Outer row count (0 = 65536) |
| cfg_y_step | input | 16 | Signed outer step in elements |
| cfg_two_d | input | 1 | 1 = two-dimensional, 0 = one row |
| cfg_circular | input | 1 | 1 = auto-reload at completion |
| cfg_irq_row | input | 1 | 1 = interrupt per row, 0 = per transfer |
| cfg_size | input | 2 | Element size code |
| xfer | input | 1 | Transfer handshake for current address |
| active | output | 1 | Sequence running, `addr` valid |
| addr | output | 32 | Current element address |
| row_end | output | 1 | Current element ends a row |
| last | output | 1 | Current element ends the transfer |
| irq | output | 1 | Interrupt pulse |
| done | output | 1 | Completion pulse |

## Verification
The assertions assume that `xfer` is only meaningful while `active` is high, and that a row-end or completion handshake is the only cause of `irq` and `done`. They also assume the address is steady whenever the handshake is absent and the channel stays enabled. The stimulus drives every input on the falling edge. It raises `xfer` only while the sequence is running, and changes configuration inputs mid-run only in the dedicated test that checks they are ignored. Expected addresses come from a closed-form row and column formula, swept over small counts, positive and negative steps, and every size code.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_WIDE = 2'd3
    } esize_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_t;

    typedef struct packed {
        logic   two_d;
        logic   circular;
        logic   irq_row;
        esize_t esize;
    } mode_t;

    function automatic logic [1:0] esize_shift(input esize_t s);
        case (s)
            ESZ_BYTE: esize_shift = 2'd0;
            ESZ_HALF: esize_shift = 2'd1;
            default:  esize_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dma2d_dim_counter.sv
module dma2d_dim_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          is_last
);
    localparam int FW = CW + 1;

    logic [FW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            if (load_val == '0)
                remaining <= {1'b1, {CW{1'b0}}};
            else
                remaining <= {1'b0, load_val};
        end else if (dec) begin
            remaining <= remaining - FW'(1);
        end
    end

    assign is_last = (remaining == FW'(1));

endmodule

// File: rtl/dma2d_addr_unit.sv
module dma2d_addr_unit #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step_en,
    input  logic          use_outer,
    input  logic [SW-1:0] inner_step,
    input  logic [SW-1:0] outer_step,
    input  logic [1:0]    shift,
    output logic [AW-1:0] addr
);
    localparam int EXT = AW - SW;

    logic [SW-1:0] sel_step;
    logic [AW-1:0] step_ext;
    logic [AW-1:0] delta;

    always_comb begin
        sel_step = use_outer ? outer_step : inner_step;
        step_ext = {{EXT{sel_step[SW-1]}}, sel_step};
        delta    = step_ext << shift;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (step_en)
            addr <= addr + delta;
    end

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic start,
    input  logic xfer,
    input  logic row_last,
    input  logic col_last,
    input  logic circ_q,
    input  logic irq_row_q,
    output logic active,
    output logic start_ok,
    output logic reload,
    output logic step_en,
    output logic inner_dec,
    output logic row_adv,
    output logic irq,
    output logic done
);
    gen_state_t state, state_nx;
    logic accept;
    logic wrap;

    always_comb begin
        accept    = (state == ST_RUN) && en && xfer;
        start_ok  = (state == ST_IDLE) && en && start;
        wrap      = accept && row_last && col_last;
        reload    = wrap && circ_q;
        step_en   = accept && !wrap;
        inner_dec = accept && !row_last;
        row_adv   = accept && row_last && !col_last;
        state_nx  = state;
        case (state)
            ST_IDLE: if (start_ok) state_nx = ST_RUN;
            ST_RUN: begin
                if (!en)
                    state_nx = ST_IDLE;
                else if (wrap && !circ_q)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            irq   <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            irq   <= accept && row_last && (irq_row_q || col_last);
            done  <= wrap;
        end
    end

    assign active = (state == ST_RUN);

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic [AW-1:0] cfg_start,
    input  logic [CW-1:0] cfg_x_count,
    input  logic [SW-1:0] cfg_x_step,
    input  logic [CW-1:0] cfg_y_count,
    input  logic [SW-1:0] cfg_y_step,
    input  logic          cfg_two_d,
    input  logic          cfg_circular,
    input  logic          cfg_irq_row,
    input  logic [1:0]    cfg_size,
    input  logic          xfer,
    output logic          active,
    output logic [AW-1:0] addr,
    output logic          row_end,
    output logic          last,
    output logic          irq,
    output logic          done
);
    localparam logic [CW-1:0] ONE_ROW = CW'(1);

    // captured configuration
    logic [AW-1:0] start_q;
    logic [CW-1:0] x_count_q;
    logic [CW-1:0] y_count_q;
    logic [SW-1:0] x_step_q;
    logic [SW-1:0] y_step_q;
    mode_t         mode_q;
    mode_t         mode_in;

    // control strobes
    logic start_ok, reload, step_en, inner_dec, row_adv;
    logic row_last, col_last;
    logic load_all;

    // load sources
    logic [AW-1:0] src_start;
    logic [CW-1:0] src_x_count;
    logic [CW-1:0] src_y_rows;
    logic [CW-1:0] inner_val;

    always_comb begin
        mode_in.two_d    = cfg_two_d;
        mode_in.circular = cfg_circular;
        mode_in.irq_row  = cfg_irq_row;
        mode_in.esize    = esize_t'(cfg_size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= '0;
            x_count_q <= '0;
            y_count_q <= '0;
            x_step_q  <= '0;
            y_step_q  <= '0;
            mode_q    <= '0;
        end else if (start_ok) begin
            start_q   <= cfg_start;
            x_count_q <= cfg_x_count;
            y_count_q <= cfg_y_count;
            x_step_q  <= cfg_x_step;
            y_step_q  <= cfg_y_step;
            mode_q    <= mode_in;
        end
    end

    always_comb begin
        load_all = start_ok || reload;
        if (start_ok) begin
            src_start   = cfg_start;
            src_x_count = cfg_x_count;
            src_y_rows  = cfg_two_d ? cfg_y_count : ONE_ROW;
        end else begin
            src_start   = start_q;
            src_x_count = x_count_q;
            src_y_rows  = mode_q.two_d ? y_count_q : ONE_ROW;
        end
        inner_val = load_all ? src_x_count : x_count_q;
    end

    dma2d_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start     (start),
        .xfer      (xfer),
        .row_last  (row_last),
        .col_last  (col_last),
        .circ_q    (mode_q.circular),
        .irq_row_q (mode_q.irq_row),
        .active    (active),
        .start_ok  (start_ok),
        .reload    (reload),
        .step_en   (step_en),
        .inner_dec (inner_dec),
        .row_adv   (row_adv),
        .irq       (irq),
        .done      (done)
    );

    dma2d_dim_counter #(.CW(CW)) i_inner (
        .clk      (clk),
        .rst      (rst),
        .load     (load_all || row_adv),
        .load_val (inner_val),
        .dec      (inner_dec),
        .is_last  (row_last)
    );

    dma2d_dim_counter #(.CW(CW)) i_outer (
        .clk      (clk),
        .rst      (rst),
        .load     (load_all),
        .load_val (src_y_rows),
        .dec      (row_adv),
        .is_last  (col_last)
    );

    dma2d_addr_unit #(.AW(AW), .SW(SW)) i_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (load_all),
        .load_addr  (src_start),
        .step_en    (step_en),
        .use_outer  (row_last),
        .inner_step (x_step_q),
        .outer_step (y_step_q),
        .shift      (esize_shift(mode_q.esize)),
        .addr       (addr)
    );

    assign row_end = active && row_last;
    assign last    = active && row_last && col_last;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          start,
    input logic          xfer,
    input logic          active,
    input logic [AW-1:0] addr,
    input logic          row_end,
    input logic          last,
    input logic          irq,
    input logic          done
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!active && !irq && !done)); // R1

    AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (rst)
        (!active && en && start) |=> active); // R2

    AST_LAST_IS_ROW_END: assert property (@(posedge clk) disable iff (rst)
        last |-> row_end); // R4

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (active && en && xfer && last) |=> done); // R7

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active && en && xfer && last)); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(active && en && xfer && row_end)); // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (active && !en) |=> (!active && !irq && !done)); // R11

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && en && !xfer) |=> $stable(addr)); // R12

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_start = '0;
    logic [15:0] cfg_x_count = '0;
    logic [15:0] cfg_x_step = '0;
    logic [15:0] cfg_y_count = '0;
    logic [15:0] cfg_y_step = '0;
    logic        cfg_two_d = 1'b0;
    logic        cfg_circular = 1'b0;
    logic        cfg_irq_row = 1'b0;
    logic [1:0]  cfg_size = '0;
    logic        xfer = 1'b0;
    logic        active;
    logic [31:0] addr;
    logic        row_end;
    logic        last;
    logic        irq;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dma2d_addr_gen i_dma2d_addr_gen (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .cfg_start(cfg_start), .cfg_x_count(cfg_x_count), .cfg_x_step(cfg_x_step),
        .cfg_y_count(cfg_y_count), .cfg_y_step(cfg_y_step), .cfg_two_d(cfg_two_d),
        .cfg_circular(cfg_circular), .cfg_irq_row(cfg_irq_row), .cfg_size(cfg_size),
        .xfer(xfer), .active(active), .addr(addr), .row_end(row_end),
        .last(last), .irq(irq), .done(done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            finish_run();
        end
    end

    task automatic run_block(input logic [31:0] sa, input int xc, input int xs,
                             input int yc, input int ys, input bit two_d,
                             input bit circ, input bit irqrow, input int sz,
                             input int passes, input bit gap, input bit poke);
        int nx, ny, bytes;
        longint off;
        logic [31:0] e;
        bit rowend, lastel;
        string tag;
        nx = (xc == 0) ? 65536 : xc;
        ny = two_d ? ((yc == 0) ? 65536 : yc) : 1;
        bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        cfg_start = sa; cfg_x_count = xc[15:0]; cfg_x_step = xs[15:0];
        cfg_y_count = yc[15:0]; cfg_y_step = ys[15:0]; cfg_two_d = two_d;
        cfg_circular = circ; cfg_irq_row = irqrow; cfg_size = sz[1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 active after start", {63'd0, active}, 64'd1);
        for (int p = 0; p < passes; p++) begin
            for (int r = 0; r < ny; r++) begin
                for (int c = 0; c < nx; c++) begin
                    off = longint'(bytes) * (longint'(r) * (longint'(nx - 1) * xs + ys)
                          + longint'(c) * xs);
                    e = sa + off[31:0];
                    rowend = (c == nx - 1);
                    lastel = rowend && (r == ny - 1);
                    if (gap && c == 1) begin
                        @(negedge clk);
                        chk("R12 address held without xfer", {32'd0, addr}, {32'd0, e});
                    end
                    if (poke && p == 0 && r == 0 && c == 1) begin
                        cfg_start = ~sa; cfg_x_count = 16'd7; cfg_y_step = 16'd99;
                        start = 1'b1;
                        @(negedge clk);
                        start = 1'b0;
                        chk("R10 start while active ignored (addr)", {32'd0, addr}, {32'd0, e});
                        chk("R10 start while active ignored (active)", {63'd0, active}, 64'd1);
                    end
                    if (c > 0) tag = "R3 inner step address";
                    else if (r > 0) tag = "R4 outer step address";
                    else if (p > 0) tag = "R8 reloaded address";
                    else tag = "R2 start address";
                    chk(tag, {32'd0, addr}, {32'd0, e});
                    chk((xc == 0) ? "R6 row_end with zero count" : "R4 row_end",
                        {63'd0, row_end}, {63'd0, rowend});
                    chk(two_d ? "R4 last" : "R5 last in one-dimensional mode",
                        {63'd0, last}, {63'd0, lastel});
                    xfer = 1'b1;
                    @(negedge clk);
                    xfer = 1'b0;
                    chk("R9 irq", {63'd0, irq}, {63'd0, irqrow ? rowend : lastel});
                    chk("R7 done pulse", {63'd0, done}, {63'd0, lastel});
                    chk((lastel && !circ) ? "R7 stop after last" : "R8 stays active",
                        {63'd0, active}, {63'd0, !(lastel && !circ)});
                end
            end
        end
        if (circ) begin
            en = 1'b0;
            @(negedge clk);
            chk("R11 disable ends circular run", {63'd0, active}, 64'd0);
            en = 1'b1;
        end
    endtask

    initial begin
        int sel;
        int xs_list[2];
        int ys_list[3];
        xs_list = '{-3, 2};
        ys_list = '{-5, 1, 6};
        repeat (3) @(negedge clk);
        chk("R1 reset active", {63'd0, active}, 64'd0);
        chk("R1 reset irq", {63'd0, irq}, 64'd0);
        chk("R1 reset done", {63'd0, done}, 64'd0);
        rst = 1'b0;
        en = 1'b1;
        @(negedge clk);

        // plain rectangle with per-row interrupts
        run_block(32'h0000_1000, 4, 1, 3, 1, 1'b1, 1'b0, 1'b1, 0, 1, 1'b1, 1'b0);
        // de-interleave three streams, outer step below inner step
        run_block(32'h0002_0000, 4, 3, 3, -8, 1'b1, 1'b0, 1'b0, 1, 1, 1'b0, 1'b0);

        // sweep of small shapes, steps and sizes
        sel = 0;
        for (int xc = 1; xc <= 3; xc++)
            for (int yc = 1; yc <= 3; yc++)
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 3; b++)
                        for (int sz = 0; sz < 4; sz++) begin
                            sel++;
                            run_block(32'h8000_0000 + 32'(sel * 16), xc, xs_list[a], yc,
                                      ys_list[b], 1'b1, sel[0], sel[1], sz,
                                      sel[0] ? 2 : 1, sel[2], 1'b0);
                        end

        // one-dimensional mode ignores the outer count
        run_block(32'h0000_0010, 5, -1, 7, 100, 1'b0, 1'b0, 1'b1, 2, 1, 1'b0, 1'b0);
        // start during active is ignored, circular keeps captured settings
        run_block(32'h0040_0000, 3, 2, 2, -3, 1'b1, 1'b1, 1'b0, 1, 2, 1'b0, 1'b1);

        // abort by disabling the channel
        cfg_start = 32'h100; cfg_x_count = 16'd5; cfg_x_step = 16'd1;
        cfg_two_d = 1'b0; cfg_circular = 1'b0; cfg_irq_row = 1'b1; cfg_size = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        xfer = 1'b1;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        xfer = 1'b0;
        chk("R11 inactive after disable", {63'd0, active}, 64'd0);
        chk("R11 no irq after disable", {63'd0, irq}, 64'd0);
        chk("R11 no done after disable", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R11 still inactive", {63'd0, active}, 64'd0);
        en = 1'b1;
        @(negedge clk);

        // count of zero means 65536 elements
        run_block(32'h0100_0000, 0, 1, 1, 0, 1'b0, 1'b0, 1'b0, 0, 1, 1'b0, 1'b0);

        finish_run();
    end

endmodule